// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-side register set of a byte-wide printer port, with a model of the attached printer built in. A host reaches three byte registers through a small synchronous bus that has an address, write and read enables and write and read data. The registers are an outbound data latch, a printer status byte and a port control byte. Reads are registered, so the selected byte appears on `rdata` in the cycle after the read enable and stays there until the next accepted read.

The printer model answers the host's handshake. A control write that raises strobe, with select and init high, marks the printer busy. If strobe was low before, the write also sends the outbound byte as a one-cycle `send_valid` pulse. Dropping strobe again can raise a pending interrupt. Later status reads step the acknowledge and busy bits back to idle. A control write with init low resets the printer's status. An inbound data latch, loaded from `rev_data` by `rev_load`, is shown in place of the outbound byte when the direction bit selects input. The level interrupt `irq` is a registered copy of the pending flag.

Top module: `lpt_regblock`

## Requirements
- R1: After reset, reads return 0xFF at offset 0, 0xD9 at offset 1 and 0xCC at offset 2. `irq` and `send_valid` are low, `rdata` reads 0xFF before any read, and `send_byte` is 0xFF.
- R2: Only the low three address bits select a register: 0 is data, 1 is status and 2 is control. An accepted read loads `rdata` at the clock edge, and the value holds until the next accepted read. Reads at offsets 3 to 7 return 0xFF, and writes there change no register.
- R3: A control write stores the write data with bits 7 and 6 forced to 1, and a control read returns the stored byte.
- R4: A control write with bit 2 (init) at 0 sets status to exactly 0xD8: bit7 not-busy, bit6 ack, bit4 online and bit3 not-error. All other status bits, including bit0 timeout, are cleared.
- R5: A control write with init (bit2), select (bit3) and strobe (bit0) all 1 clears status bit7. If the stored control strobe bit was 0 before the write, `send_valid` is high for exactly the cycle after the write, with `send_byte` equal to the outbound data byte.
- R6: A control write with init and select at 1 and strobe at 0 sets the pending interrupt only if bit4 of the control byte stored before the write is 1. The interrupt enable in the new value plays no part. `irq` follows the pending flag from the cycle after the write.
- R7: A status read returns the status as it stood before the read, and clears `irq`. After the read, if status bit7 is 0 and the stored control strobe is 0, the handshake advances. When bit6 is set it is cleared; otherwise bits 6 and 7 are both set.
- R8: A data read returns the inbound latch when control bit5 is 1, and the outbound latch when it is 0. `rev_load` loads the inbound latch from `rev_data`.
- R9: When `wr_en` and `rd_en` are high together, only the write takes place. `rdata` holds, and a status address does not clear `irq`.
- R10: Writes to the status offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | Register offset; only the low 3 bits are decoded |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe for the addressed register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rev_data | input | 8 | Inbound byte from the printer side |
| rev_load | input | 1 | Loads `rev_data` into the inbound latch |
| irq | output | 1 | Level interrupt request |
| send_valid | output | 1 | One-cycle pulse carrying an outbound byte |
| send_byte | output | 8 | Byte sent with `send_valid` |

## Verification
A table of writes, loads and reads exercises the register set in several patterns:
- reads straight after reset;
- writes to unused and status offsets, to show they are ignored;
- control writes with init low, to separate a status reset from a strobe;
- a full strobe-high, strobe-low, status-read sequence, to show the ack and busy steps in order;
- switching the direction bit, to show which data latch is presented.

Directed tests then check that the send pulse appears only on a rising strobe, and that the interrupt follows the enable bit already stored, not the one being written. They also check that a write and a read in the same cycle leave both `rdata` and `irq` unchanged.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_SEL_W = 3;

  localparam logic [REG_SEL_W-1:0] OFS_DATA = 3'd0;
  localparam logic [REG_SEL_W-1:0] OFS_STAT = 3'd1;
  localparam logic [REG_SEL_W-1:0] OFS_CTRL = 3'd2;

  // status bit positions
  localparam int ST_NBUSY  = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_NERR   = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_AFD  = 1;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] STAT_IDLE  = 8'hD8;
  localparam logic [BYTE_W-1:0] STAT_RST   = STAT_IDLE | 8'h01;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RST   = CTRL_FORCE | 8'h0C;
  localparam logic [BYTE_W-1:0] BYTE_ONES  = 8'hFF;

  typedef struct packed {
    logic                 wr_data;
    logic                 wr_ctrl;
    logic                 rd_stat;
    logic                 rd_any;
    logic [REG_SEL_W-1:0] sel;
  } host_evt_t;
endpackage

// File: rtl/lpt_host_if.sv
module lpt_host_if
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output host_evt_t         evt
);
  logic [REG_SEL_W-1:0] sel;
  logic                 rd_ok;

  assign sel   = addr[REG_SEL_W-1:0];
  // a write in the same cycle takes precedence over a read
  assign rd_ok = rd_en & ~wr_en;

  always_comb begin
    evt         = '0;
    evt.sel     = sel;
    evt.wr_data = wr_en & (sel == OFS_DATA);
    evt.wr_ctrl = wr_en & (sel == OFS_CTRL);
    evt.rd_stat = rd_ok & (sel == OFS_STAT);
    evt.rd_any  = rd_ok;
  end
endmodule

// File: rtl/lpt_ctrl_status.sv
module lpt_ctrl_status
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  host_evt_t         evt,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              fire,
  output logic              irq
);
  logic [BYTE_W-1:0] ctrl_n, stat_n, wval;
  logic              pend_q, pend_n;
  logic              state_en, irq_en;

  assign wval     = wdata | CTRL_FORCE;
  assign state_en = evt.wr_ctrl | evt.rd_stat;
  assign irq_en   = evt.wr_ctrl | evt.wr_data | evt.rd_stat;

  always_comb begin
    ctrl_n = ctrl_q;
    stat_n = stat_q;
    pend_n = pend_q;
    fire   = 1'b0;
    if (evt.wr_ctrl) begin
      ctrl_n = wval;
      if (!wval[CT_INIT]) begin
        stat_n = STAT_IDLE;
      end else if (wval[CT_SEL]) begin
        if (wval[CT_STB]) begin
          stat_n[ST_NBUSY] = 1'b0;
          fire             = ~ctrl_q[CT_STB];
        end else if (ctrl_q[CT_IEN]) begin
          pend_n = 1'b1;
        end
      end
    end else if (evt.rd_stat) begin
      pend_n = 1'b0;
      if (!stat_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_n[ST_ACK] = 1'b0;
        end else begin
          stat_n[ST_ACK]   = 1'b1;
          stat_n[ST_NBUSY] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
    end else if (state_en) begin
      ctrl_q <= ctrl_n;
      stat_q <= stat_n;
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (irq_en) begin
      irq <= pend_n;
    end
  end
endmodule

// File: rtl/lpt_data_path.sv
module lpt_data_path
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rev_load,
  input  logic [BYTE_W-1:0] rev_data,
  input  logic              fire,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] in_q,
  output logic              send_valid,
  output logic [BYTE_W-1:0] send_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= BYTE_ONES;
    end else if (wr_data) begin
      out_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= BYTE_ONES;
    end else if (rev_load) begin
      in_q <= rev_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_valid <= 1'b0;
    end else begin
      send_valid <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_byte <= BYTE_ONES;
    end else if (fire) begin
      send_byte <= out_q;
    end
  end
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
  import lpt_pkg::*;
#(
  parameter bit RDATA_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_evt_t         evt,
  input  logic [BYTE_W-1:0] out_q,
  input  logic [BYTE_W-1:0] in_q,
  input  logic [BYTE_W-1:0] ctrl_q,
  input  logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] rd_val;

  always_comb begin
    case (evt.sel)
      OFS_DATA: rd_val = ctrl_q[CT_DIR] ? in_q : out_q;
      OFS_STAT: rd_val = stat_q;
      OFS_CTRL: rd_val = ctrl_q;
      default:  rd_val = BYTE_ONES;
    endcase
  end

  generate
    if (RDATA_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdata <= BYTE_ONES;
        end else if (evt.rd_any) begin
          rdata <= rd_val;
        end
      end
    end else begin : g_comb
      assign rdata = rd_val;
    end
  endgenerate
endmodule

// File: rtl/lpt_regblock.sv
module lpt_regblock
  import lpt_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter bit RDATA_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] rev_data,
  input  logic              rev_load,
  output logic              irq,
  output logic              send_valid,
  output logic [BYTE_W-1:0] send_byte
);
  logic              rst_meta, rst_sync_n;
  host_evt_t         evt;
  logic [BYTE_W-1:0] ctrl_q, stat_q, out_q, in_q;
  logic              fire;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  lpt_host_if #(.ADDR_W(ADDR_W)) u_host (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .evt   (evt)
  );

  lpt_ctrl_status u_cs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (evt),
    .wdata  (wdata),
    .ctrl_q (ctrl_q),
    .stat_q (stat_q),
    .fire   (fire),
    .irq    (irq)
  );

  lpt_data_path u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_data    (evt.wr_data),
    .wdata      (wdata),
    .rev_load   (rev_load),
    .rev_data   (rev_data),
    .fire       (fire),
    .out_q      (out_q),
    .in_q       (in_q),
    .send_valid (send_valid),
    .send_byte  (send_byte)
  );

  lpt_rd_mux #(.RDATA_REG(RDATA_REG)) u_rd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (evt),
    .out_q  (out_q),
    .in_q   (in_q),
    .ctrl_q (ctrl_q),
    .stat_q (stat_q),
    .rdata  (rdata)
  );
endmodule

// File: rtl/lpt_regblock_chk.sv
module lpt_regblock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq,
  input logic       send_valid,
  input logic [7:0] stat_q
);
  a_r2_unused_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel > 3'd2) |=> rdata == 8'hFF);

  a_r3_ctrl_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel == 3'd2) |=> rdata[7:6] == 2'b11);

  a_r4_init_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 3'd2 && !wdata[2]) |=> stat_q == 8'hD8);

  a_r5_send_single: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |=> !send_valid);

  a_r5_send_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> $past(wr_en && sel == 3'd2 && wdata[0] && wdata[2] && wdata[3]));

  a_r7_stat_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel == 3'd1) |=> !irq);

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (sel == 3'd0 || sel == 3'd2)) && !(rd_en && !wr_en && sel == 3'd1))
      |=> $stable(irq));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rdata));
endmodule

bind lpt_regblock lpt_regblock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sel        (addr[2:0]),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .irq        (irq),
  .send_valid (send_valid),
  .stat_q     (stat_q)
);

// File: tb/tb_lpt_regblock.sv
module tb_lpt_regblock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rev_load = 1'b0;
  logic [7:0] wdata = '0, rev_data = '0;
  logic [7:0] rdata, send_byte;
  logic       irq, send_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lpt_regblock dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rev_data(rev_data), .rev_load(rev_load),
    .irq(irq), .send_valid(send_valid), .send_byte(send_byte)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_LD = 2'd2;
  localparam int NV = 30;
  // {op, addr, data, expected, requirement number}
  localparam logic [24:0] VEC [NV] = '{
    {OP_RD, 3'd2, 8'h00, 8'hCC, 4'd1},  // R1 control at reset
    {OP_RD, 3'd1, 8'h00, 8'hD9, 4'd1},  // R1 status at reset
    {OP_RD, 3'd0, 8'h00, 8'hFF, 4'd1},  // R1 data at reset
    {OP_RD, 3'd5, 8'h00, 8'hFF, 4'd2},  // R2 unused offset
    {OP_WR, 3'd0, 8'hA5, 8'h00, 4'd0},
    {OP_RD, 3'd0, 8'h00, 8'hA5, 4'd8},  // R8 outbound latch
    {OP_WR, 3'd7, 8'h00, 8'h00, 4'd0},
    {OP_RD, 3'd0, 8'h00, 8'hA5, 4'd2},  // R2 unused write ignored
    {OP_RD, 3'd2, 8'h00, 8'hCC, 4'd2},  // R2 unused write ignored
    {OP_WR, 3'd2, 8'h08, 8'h00, 4'd0},
    {OP_RD, 3'd2, 8'h00, 8'hC8, 4'd3},  // R3 forced bits
    {OP_RD, 3'd1, 8'h00, 8'hD8, 4'd4},  // R4 init resets status
    {OP_WR, 3'd2, 8'h1C, 8'h00, 4'd0},
    {OP_RD, 3'd2, 8'h00, 8'hDC, 4'd3},  // R3
    {OP_WR, 3'd2, 8'h1D, 8'h00, 4'd0},
    {OP_RD, 3'd1, 8'h00, 8'h58, 4'd5},  // R5 busy after strobe
    {OP_RD, 3'd1, 8'h00, 8'h58, 4'd7},  // R7 no step while strobe high
    {OP_WR, 3'd2, 8'h1C, 8'h00, 4'd0},
    {OP_RD, 3'd1, 8'h00, 8'h58, 4'd7},  // R7 value before step
    {OP_RD, 3'd1, 8'h00, 8'h18, 4'd7},  // R7 ack cleared
    {OP_RD, 3'd1, 8'h00, 8'hD8, 4'd7},  // R7 ack and not-busy set
    {OP_WR, 3'd1, 8'hFF, 8'h00, 4'd0},
    {OP_RD, 3'd1, 8'h00, 8'hD8, 4'd10}, // R10 status write ignored
    {OP_WR, 3'd2, 8'h3C, 8'h00, 4'd0},
    {OP_RD, 3'd0, 8'h00, 8'hFF, 4'd8},  // R8 inbound latch at reset
    {OP_LD, 3'd0, 8'h3C, 8'h00, 4'd0},
    {OP_RD, 3'd0, 8'h00, 8'h3C, 4'd8},  // R8 inbound latch loaded
    {OP_WR, 3'd2, 8'h0C, 8'h00, 4'd0},
    {OP_RD, 3'd0, 8'h00, 8'hA5, 4'd8},  // R8 direction back to output
    {OP_RD, 3'd1, 8'h00, 8'hD8, 4'd7}   // R7
  };

  task automatic check(input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc_op(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d);
    addr = a;
    case (op)
      OP_WR: begin wr_en = 1'b1; wdata = d; end
      OP_RD: rd_en = 1'b1;
      default: begin rev_load = 1'b1; rev_data = d; end
    endcase
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; rev_load = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 outputs straight after reset
    check(1, "irq after reset", {7'd0, irq}, 8'h00);
    check(1, "send_valid after reset", {7'd0, send_valid}, 8'h00);
    check(1, "rdata before any read", rdata, 8'hFF);
    check(1, "send_byte after reset", send_byte, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      cyc_op(VEC[i][24:23], VEC[i][22:20], VEC[i][19:12]);
      if (VEC[i][24:23] == OP_RD)
        check(int'(VEC[i][3:0]), $sformatf("vector %0d", i), rdata, VEC[i][11:4]);
    end

    // R5 send pulse only on a rising strobe
    cyc_op(OP_WR, 3'd0, 8'h3A);
    cyc_op(OP_WR, 3'd2, 8'h0C);
    cyc_op(OP_WR, 3'd2, 8'h0D);
    check(5, "send_valid on rising strobe", {7'd0, send_valid}, 8'h01);
    check(5, "send_byte", send_byte, 8'h3A);
    @(negedge clk);
    check(5, "send_valid one cycle", {7'd0, send_valid}, 8'h00);
    cyc_op(OP_WR, 3'd2, 8'h0D);
    check(5, "no send with strobe already high", {7'd0, send_valid}, 8'h00);

    // R6 interrupt follows the stored enable bit
    cyc_op(OP_WR, 3'd2, 8'h1C);
    check(6, "irq with stored enable low", {7'd0, irq}, 8'h00);
    cyc_op(OP_WR, 3'd2, 8'h1C);
    check(6, "irq with stored enable high", {7'd0, irq}, 8'h01);
    cyc_op(OP_RD, 3'd1, 8'h00);
    check(7, "status read clears irq", {7'd0, irq}, 8'h00);
    cyc_op(OP_WR, 3'd2, 8'h0C);
    check(6, "irq set by old enable though new is low", {7'd0, irq}, 8'h01);
    cyc_op(OP_RD, 3'd1, 8'h00);
    check(7, "irq cleared again", {7'd0, irq}, 8'h00);

    // R9 write wins over read in the same cycle
    cyc_op(OP_WR, 3'd2, 8'h1C);
    cyc_op(OP_WR, 3'd2, 8'h1C);
    cyc_op(OP_RD, 3'd2, 8'h00);
    held = rdata;
    addr = 3'd1; wdata = 8'h00; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(9, "irq kept on collided status read", {7'd0, irq}, 8'h01);
    check(9, "rdata held on collision", rdata, held);
    cyc_op(OP_RD, 3'd2, 8'h00);
    check(10, "control untouched by status write", rdata, 8'hDC);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule